// File: doc/BRIEF.md
# Interlace Field Parity Detector

This block works out which field of an interlaced picture is being received. It follows the horizontal line grid by running a line-phase counter. The counter restarts on each falling edge of the active-low composite sync that lands near a line boundary. When a vertical-start strobe arrives, the block reads where in the line that strobe fell. A strobe in the first half of the line marks an odd field. A strobe in the second half marks an even field, because the two fields sit half a line apart.

The block compares each field's parity with the parity of the field before it. When the two differ, the field-parity output follows the new value and the interlaced flag is set. When two fields in a row have the same parity, the source is treated as progressive: the output keeps its value and the flag drops. The line period is an input counted in clock cycles, so a single build can serve several scan rates. Detecting the vertical event itself belongs to a neighbouring block.

Top module: `field_parity_detector`

## Requirements
- R1: While reset is asserted, and until the first valid vertical start after it, `oddEven` and `interlaced` are both 0.
- R2: A `vStart` strobe that arrives before any sync falling edge has been accepted since reset is ignored, and both outputs stay 0.
- R3: After the first accepted edge, a falling edge of `csyncN` is accepted as a line start only when the line phase is within `linePeriod>>2` cycles of a line boundary. Falling edges near mid-line (half-line equalizing and serration pulses) leave the phase untouched.
- R4: A valid vertical start seen at line phase below `linePeriod>>1` gives odd parity (1). A start at or above that value gives even parity (0). The phase is 0 in the cycle where an accepted sync edge is seen and grows by one each cycle after it.
- R5: The first valid vertical start after reset loads its parity into `oddEven` and leaves `interlaced` at 0.
- R6: A later vertical start whose parity differs from the previous field's parity loads the new parity into `oddEven` and sets `interlaced` to 1.
- R7: A later vertical start whose parity equals the previous field's parity leaves `oddEven` unchanged and clears `interlaced` to 0.
- R8: The outputs change only in the cycle that follows a valid `vStart`. In the cycle of the strobe itself they still show the old values.
- R9: When a line arrives without a sync edge, the phase wraps from `linePeriod-1` to 0 on its own, so parity stays correct across a missing sync pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| csyncN | input | 1 | Composite sync, active low, synchronous to clk |
| vStart | input | 1 | One-cycle strobe marking the start of vertical sync |
| linePeriod | input | LINE_W | Line length in clock cycles (8 or more) |
| oddEven | output | 1 | Field parity: 1 for odd, 0 for even |
| interlaced | output | 1 | 1 when the last two fields had opposite parity |

## Verification
The bench builds the block with the default `LINE_W` of 8, so every line period from 24 up to the full 255 cycles can be reached. It resets the block with a new random period for each group of fields. Because periods can be odd, the half-line split at `linePeriod>>1` gets exercised with rounding, on both sides of the boundary. The 8-bit width also lets a directed case sit the phase at its largest value (vertical start at the last cycle of a line) and run lines with no sync edge through the counter wrap.

// File: rtl/oefd_pkg.sv
package oefd_pkg;
  // Strobes from control to the field datapath, valid in the current cycle
  typedef struct packed {
    logic lineStart;   // accepted horizontal sync edge: restart line phase
    logic fieldStart;  // valid vertical start: evaluate parity
    logic firstField;  // first valid vertical start since reset
  } oefdStrobe_t;
endpackage

// File: rtl/oefd_ctrl.sv
module oefd_ctrl
  import oefd_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csyncN,
  input  logic              vStart,
  input  logic [LINE_W-1:0] linePeriod,
  input  logic [LINE_W-1:0] phase,
  output oefdStrobe_t       strb
);
  logic              csyncQ;
  logic              lockedQ;
  logic              seenFieldQ;
  logic              syncFall;
  logic              inWindow;
  logic [LINE_W-1:0] tol;

  always_comb begin
    tol      = linePeriod >> 2;
    syncFall = csyncQ & ~csyncN;
    inWindow = (phase < tol) || (phase >= (linePeriod - tol));
    strb.lineStart  = syncFall & (~lockedQ | inWindow);
    strb.fieldStart = vStart & (lockedQ | strb.lineStart);
    strb.firstField = strb.fieldStart & ~seenFieldQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csyncQ     <= 1'b1;
      lockedQ    <= 1'b0;
      seenFieldQ <= 1'b0;
    end else begin
      csyncQ <= csyncN;
      if (strb.lineStart)  lockedQ    <= 1'b1;
      if (strb.fieldStart) seenFieldQ <= 1'b1;
    end
  end

  // R2: lock comes only from a sync falling edge
  a_r2_lock_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    !lockedQ |=> (lockedQ == $past(syncFall)));

  // R5: the first-field strobe occurs at most once per reset
  a_r5_single_first_field: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstField |=> !strb.firstField && seenFieldQ);
endmodule

// File: rtl/oefd_field_path.sv
module oefd_field_path
  import oefd_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  oefdStrobe_t       strb,
  input  logic [LINE_W-1:0] linePeriod,
  output logic [LINE_W-1:0] phase,
  output logic              oddEven,
  output logic              interlaced
);
  logic [LINE_W-1:0] phaseQ;
  logic [LINE_W-1:0] phaseNow;
  logic [LINE_W-1:0] phaseNext;
  logic [LINE_W-1:0] halfLine;
  logic              fieldParity;
  logic              lastParityQ;
  logic              oddEvenQ;
  logic              interlacedQ;

  always_comb begin
    phaseNow    = strb.lineStart ? '0 : phaseQ;
    phaseNext   = (phaseNow >= (linePeriod - LINE_W'(1))) ? '0 : (phaseNow + LINE_W'(1));
    halfLine    = linePeriod >> 1;
    fieldParity = (phaseNow < halfLine);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ      <= '0;
      lastParityQ <= 1'b0;
      oddEvenQ    <= 1'b0;
      interlacedQ <= 1'b0;
    end else begin
      phaseQ <= phaseNext;
      if (strb.fieldStart) begin
        lastParityQ <= fieldParity;
        if (strb.firstField) begin
          oddEvenQ    <= fieldParity;
          interlacedQ <= 1'b0;
        end else if (fieldParity != lastParityQ) begin
          oddEvenQ    <= fieldParity;
          interlacedQ <= 1'b1;
        end else begin
          interlacedQ <= 1'b0;
        end
      end
    end
  end

  assign phase      = phaseQ;
  assign oddEven    = oddEvenQ;
  assign interlaced = interlacedQ;

  // R8: parity output moves only after a valid vertical start
  a_r8_parity_only_at_field: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fieldStart |=> $stable(oddEvenQ));

  // R8: interlace flag moves only after a valid vertical start
  a_r8_flag_only_at_field: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fieldStart |=> $stable(interlacedQ));

  // R5: first field never reports interlace
  a_r5_first_not_interlaced: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstField |=> !interlacedQ);

  // R3: an accepted line start restarts the phase
  a_r3_line_restarts_phase: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineStart && (linePeriod > LINE_W'(1)) |=> (phaseQ == LINE_W'(1)));

  // R9: phase stays inside the line while the period is steady
  a_r9_phase_in_range: assert property (@(posedge clk) disable iff (!rstN)
    $stable(linePeriod) && (linePeriod != '0) |=> (phaseQ < linePeriod));
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector
  import oefd_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csyncN,
  input  logic              vStart,
  input  logic [LINE_W-1:0] linePeriod,
  output logic              oddEven,
  output logic              interlaced
);
  oefdStrobe_t       strb;
  logic [LINE_W-1:0] phase;

  oefd_ctrl #(.LINE_W(LINE_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .csyncN     (csyncN),
    .vStart     (vStart),
    .linePeriod (linePeriod),
    .phase      (phase),
    .strb       (strb)
  );

  oefd_field_path #(.LINE_W(LINE_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .linePeriod (linePeriod),
    .phase      (phase),
    .oddEven    (oddEven),
    .interlaced (interlaced)
  );
endmodule

// File: tb/tb_field_parity_detector.sv
module tb_field_parity_detector;
  localparam int LINE_W = 8;
  localparam int SYNC_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              csyncN = 1'b1;
  logic              vStart = 1'b0;
  logic [LINE_W-1:0] linePeriod = 8'd64;
  logic              oddEven;
  logic              interlaced;

  int  total = 0;
  int  fails = 0;
  int  P = 64;
  bit  locked, seen;
  logic expOe, expIl, lastPar;

  always #4 clk = ~clk;

  field_parity_detector #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rstN(rstN), .csyncN(csyncN), .vStart(vStart),
    .linePeriod(linePeriod), .oddEven(oddEven), .interlaced(interlaced)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (P=%0d)", req, act, exp, P);
    end
  endtask

  task automatic doReset(int newP);
    @(negedge clk);
    rstN = 1'b0; P = newP; linePeriod = LINE_W'(newP);
    csyncN = 1'b1; vStart = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oddEven in reset", oddEven, 1'b0);
    chk("R1 interlaced in reset", interlaced, 1'b0);
    rstN = 1'b1;
    locked = 0; seen = 0; expOe = 0; expIl = 0; lastPar = 0;
  endtask

  // Model of the field decision, from the requirements
  function automatic logic parityOf(int vAt);
    return (vAt < (P / 2)) ? 1'b1 : 1'b0;
  endfunction

  // One line: optional line sync, optional mid-line pulse, optional vStart at vAt
  task automatic runLine(bit lineSync, bit halfPulse, int vAt, string tag);
    bit fired = 0;
    bit gotEdge = 0;
    for (int c = 0; c < P; c++) begin
      csyncN = !((lineSync && c < SYNC_W) ||
                 (halfPulse && c >= P / 2 && c < P / 2 + SYNC_W));
      vStart = (c == vAt);
      if (lineSync && c == 0) gotEdge = 1;
      if (c == vAt) begin
        chk("R8 oddEven before update", oddEven, expOe);
        chk("R8 interlaced before update", interlaced, expIl);
        if (locked || gotEdge) begin
          logic p = parityOf(vAt);
          fired = 1;
          if (!seen) begin expOe = p; expIl = 0; seen = 1; end
          else if (p != lastPar) begin expOe = p; expIl = 1; end
          else expIl = 0;
          lastPar = p;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    vStart = 1'b0;
    if (lineSync) locked = 1;
    if (vAt >= 0) begin
      chk(tag, oddEven, expOe);
      chk(tag, interlaced, expIl);
    end
  endtask

  // A field: a few plain lines, optional missing sync, then the vertical lines
  task automatic runField(bit odd, int d, bit missing, string tag);
    runLine(1, 0, -1, "");
    runLine(1, 0, -1, "");
    if (missing) runLine(0, 0, -1, "");
    runLine(1, 1, odd ? d : (P / 2 + d), tag);
    runLine(1, 1, -1, "");
    runLine(1, 0, -1, "");
  endtask

  initial begin
    void'($urandom(32'd2024));
    doReset(64);
    // R2: vStart before any sync edge is ignored
    runLine(0, 0, 10, "R2 vStart before lock ignored");
    runField(1, 5, 0, "R4 R5 first field odd");
    runField(0, 5, 0, "R3 R4 R6 even field after odd");
    runField(1, 2, 0, "R4 R6 odd after even");
    runField(1, 7, 0, "R7 repeated odd holds");
    runField(0, 0, 0, "R3 R4 R6 vStart exactly at half line");
    runField(1, 31, 0, "R4 R6 vStart one before half line");
    runField(0, 31, 1, "R9 R6 even after missing sync");
    runField(0, 3, 1, "R9 R7 repeated even after missing sync");

    // Odd line period at the top of the range
    doReset(255);
    runField(0, 127, 0, "R4 R5 first field even at last phase");
    runField(1, 0, 1, "R9 R6 odd at phase zero");

    // Constrained random periods and fields
    for (int g = 0; g < 5; g++) begin
      doReset(24 + int'($urandom_range(0, 231)));
      for (int f = 0; f < 5; f++) begin
        bit odd = 1'($urandom_range(0, 1));
        int d = int'($urandom_range(0, P / 2 - 1));
        bit miss = 1'($urandom_range(0, 1));
        runField(odd, d, miss, "R4 R6 R7 R9 random field");
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule